// File: doc/BRIEF.md
# Three-Wire Panel Register Writer

This block is a serial master that programs one configuration register of a display panel per transaction. It uses three lines: an active-low select, a serial clock and a data line. A requester presents a 7-bit register address and an 8-bit value with a one-cycle start strobe. The block then shifts out a single 16-bit write frame and signals completion with a one-cycle done pulse.

Two extra request inputs issue the panel's fixed standby-enter and standby-exit writes. The caller does not need to know the register or the value for these. The serial clock is derived from the system clock. Each low phase and each high phase lasts `HALF_CLKS` system clocks. The default gives about 4 µs per phase at 100 MHz.

Top module: `panel_reg_writer`

## Requirements
- R1: Out of reset and whenever no transfer is running, `pnl_cs_n` is 1, `pnl_sclk` and `pnl_sdo` are 0, and `busy_o` and `done_o` are 0.
- R2: An accepted request raises `busy_o` and pulls `pnl_cs_n` low on the next clock edge. `pnl_cs_n` then stays low with `pnl_sclk` and `pnl_sdo` at 0 for a lead-in of `HALF_CLKS` cycles before the first bit is driven.
- R3: The frame is 16 bits, sent most significant first: address bits 6 down to 0, then one write flag bit that is always 0, then data bits 7 down to 0.
- R4: Each bit is placed on `pnl_sdo` while `pnl_sclk` is low for `HALF_CLKS` cycles. `pnl_sclk` is then high for `HALF_CLKS` cycles. `pnl_sdo` does not change at the rising edge of `pnl_sclk`.
- R5: `pnl_sclk` is only high while `pnl_cs_n` is low. After the last high phase, `pnl_cs_n` returns to 1 and both other lines return to 0 for a trailing gap of `HALF_CLKS` cycles while `busy_o` stays 1.
- R6: `done_o` is high for exactly one cycle, `34*HALF_CLKS` cycles after the edge that accepted the request. `busy_o` is 0 in that same cycle.
- R7: Start and standby strobes that arrive while `busy_o` is 1 are ignored: the running frame is unchanged and no second frame follows.
- R8: `sby_enter_i` writes value 0x20 to register 0x43.
- R9: `sby_exit_i` writes value 0xE0 to register 0x43.
- R10: When strobes coincide in an idle cycle, `start_i` wins over `sby_enter_i`, and `sby_enter_i` wins over `sby_exit_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle strobe for a generic register write |
| addr_i | input | 7 | Register address for a generic write |
| data_i | input | 8 | Register value for a generic write |
| sby_enter_i | input | 1 | One-cycle strobe to put the panel in standby |
| sby_exit_i | input | 1 | One-cycle strobe to wake the panel from standby |
| busy_o | output | 1 | High while a frame is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| pnl_cs_n | output | 1 | Panel select, active low |
| pnl_sclk | output | 1 | Serial clock; the panel samples on its rising edge |
| pnl_sdo | output | 1 | Serial data to the panel |

## Verification
The assertions check, on every cycle, that the lines sit at their idle levels when nothing runs and that the clock never rises outside the select window. They also check that data never moves on a rising clock edge, that done is a single-cycle pulse that ends busy, and that a running frame is never restarted. Several properties can only be shown by the bench's scenarios, because they depend on stimulus: the bit order and content of each frame, the exact phase lengths and total frame duration, the fixed standby codes, the priority of coinciding strobes, and the fact that strobes during a transfer leave the captured frame untouched.

// File: rtl/pw_pkg.sv
package pw_pkg;
    localparam int ADDR_W  = 7;
    localparam int DATA_W  = 8;
    localparam int FRAME_W = ADDR_W + 1 + DATA_W;

    localparam logic [ADDR_W-1:0] SBY_REG     = 7'h43;
    localparam logic [DATA_W-1:0] SBY_ON_VAL  = 8'h20;
    localparam logic [DATA_W-1:0] SBY_OFF_VAL = 8'hE0;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LEAD,
        PH_LOW,
        PH_HIGH,
        PH_TRAIL
    } phase_e;
endpackage

// File: rtl/pw_req_sel.sv
module pw_req_sel
    import pw_pkg::*;
(
    input  logic                start_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [DATA_W-1:0]   data_i,
    input  logic                sby_enter_i,
    input  logic                sby_exit_i,
    output logic                req_o,
    output logic [FRAME_W-1:0]  frame_o
);
    // Write flag is the bit between address and data; 0 means write.
    always_comb begin
        req_o = start_i | sby_enter_i | sby_exit_i;
        if (start_i)
            frame_o = {addr_i, 1'b0, data_i};
        else if (sby_enter_i)
            frame_o = {SBY_REG, 1'b0, SBY_ON_VAL};
        else
            frame_o = {SBY_REG, 1'b0, SBY_OFF_VAL};
    end
endmodule

// File: rtl/pw_half_timer.sv
module pw_half_timer #(
    parameter int HALF_CLKS = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic tick_o
);
    localparam int CW = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(HALF_CLKS - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!en_i || cnt_q == '0)
            cnt_d = RELOAD;
        else
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= RELOAD;
        else        cnt_q <= cnt_d;
    end

    assign tick_o = en_i && (cnt_q == '0);

    // R4: a phase cannot end twice in a row unless a phase is one cycle long
    p_tick_spacing_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (HALF_CLKS > 1 && tick_o) |=> !tick_o);
endmodule

// File: rtl/pw_frame_tx.sv
module pw_frame_tx
    import pw_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_i,
    input  logic [FRAME_W-1:0] frame_i,
    input  logic               tick_i,
    output logic               busy_o,
    output logic               done_o,
    output logic               cs_n_o,
    output logic               sclk_o,
    output logic               sdo_o
);
    localparam int BW = $clog2(FRAME_W + 1);

    typedef struct packed {
        phase_e             ph;
        logic [FRAME_W-1:0] sh;
        logic [BW-1:0]      left;
        logic               done;
    } tx_st_t;

    tx_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (st_q.ph)
            PH_IDLE: begin
                if (req_i) begin
                    st_d.ph   = PH_LEAD;
                    st_d.sh   = frame_i;
                    st_d.left = BW'(FRAME_W);
                end
            end
            PH_LEAD: if (tick_i) st_d.ph = PH_LOW;
            PH_LOW:  if (tick_i) st_d.ph = PH_HIGH;
            PH_HIGH: begin
                if (tick_i) begin
                    if (st_q.left == BW'(1)) begin
                        st_d.ph = PH_TRAIL;
                        st_d.sh = '0;
                    end else begin
                        st_d.ph   = PH_LOW;
                        st_d.sh   = {st_q.sh[FRAME_W-2:0], 1'b0};
                        st_d.left = st_q.left - 1'b1;
                    end
                end
            end
            PH_TRAIL: begin
                if (tick_i) begin
                    st_d.ph   = PH_IDLE;
                    st_d.done = 1'b1;
                end
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{ph: PH_IDLE, sh: '0, left: '0, done: 1'b0};
        else        st_q <= st_d;
    end

    assign busy_o = (st_q.ph != PH_IDLE);
    assign done_o = st_q.done;
    assign cs_n_o = (st_q.ph == PH_IDLE) || (st_q.ph == PH_TRAIL);
    assign sclk_o = (st_q.ph == PH_HIGH);
    assign sdo_o  = ((st_q.ph == PH_LOW) || (st_q.ph == PH_HIGH)) && st_q.sh[FRAME_W-1];

    p_idle_lines_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (cs_n_o && !sclk_o && !sdo_o));

    p_clk_in_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o |-> !cs_n_o);

    p_data_setup_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_o) |-> $stable(sdo_o));

    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_ends_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));

    p_no_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && st_q.ph != PH_LEAD) |=> (st_q.ph != PH_LEAD));
endmodule

// File: rtl/panel_reg_writer.sv
module panel_reg_writer
    import pw_pkg::*;
#(
    parameter int HALF_CLKS = 400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              sby_enter_i,
    input  logic              sby_exit_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              pnl_cs_n,
    output logic              pnl_sclk,
    output logic              pnl_sdo
);
    logic               req;
    logic [FRAME_W-1:0] frame;
    logic               tick;

    pw_req_sel u_sel (
        .start_i     (start_i),
        .addr_i      (addr_i),
        .data_i      (data_i),
        .sby_enter_i (sby_enter_i),
        .sby_exit_i  (sby_exit_i),
        .req_o       (req),
        .frame_o     (frame)
    );

    pw_half_timer #(.HALF_CLKS(HALF_CLKS)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (busy_o),
        .tick_o (tick)
    );

    pw_frame_tx u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (req),
        .frame_i (frame),
        .tick_i  (tick),
        .busy_o  (busy_o),
        .done_o  (done_o),
        .cs_n_o  (pnl_cs_n),
        .sclk_o  (pnl_sclk),
        .sdo_o   (pnl_sdo)
    );
endmodule

// File: tb/panel_reg_writer_test.sv
module panel_reg_writer_test;
    localparam int CLK_PERIOD = 10;
    localparam int H = 3;

    logic clk = 0, rst_n = 0;
    logic start_i = 0, sby_enter_i = 0, sby_exit_i = 0;
    logic [6:0] addr_i = '0;
    logic [7:0] data_i = '0;
    logic busy_o, done_o, pnl_cs_n, pnl_sclk, pnl_sdo;

    always #(CLK_PERIOD/2) clk = ~clk;

    panel_reg_writer #(.HALF_CLKS(H)) uut (.*);

    int total = 0, fails = 0;
    logic [15:0] cap = '0;
    int nbits = 0, hi_cyc = 0, lo_cyc = 0, tr_cyc = 0, cs_bad = 0, tr_bad = 0;
    logic prev_sclk = 0;

    // kind (0 cmd, 1 enter, 2 exit), address, data
    localparam logic [16:0] VEC [6] = '{
        {2'd0, 7'h15, 8'h55}, {2'd0, 7'h7F, 8'h00}, {2'd0, 7'h00, 8'hFF},
        {2'd0, 7'h2A, 8'hA5}, {2'd1, 7'h00, 8'h00}, {2'd2, 7'h00, 8'h00}};

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    always @(negedge clk) begin
        if (pnl_sclk && !prev_sclk) begin
            cap = {cap[14:0], pnl_sdo};
            nbits++;
            if (pnl_cs_n) cs_bad++;
        end
        if (pnl_sclk) hi_cyc++;
        if (!pnl_cs_n && !pnl_sclk) lo_cyc++;
        if (busy_o && pnl_cs_n) begin
            tr_cyc++;
            if (pnl_sdo || pnl_sclk) tr_bad++;
        end
        prev_sclk = pnl_sclk;
    end

    task automatic run(input bit st, input bit en, input bit ex, input logic [6:0] a,
                       input logic [7:0] d, input logic [15:0] expf, input string tag,
                       input bit disturb);
        int cnt = 0;
        int leadbad = 0;
        bit got = 0;
        @(negedge clk);
        cap = '0; nbits = 0; hi_cyc = 0; lo_cyc = 0; tr_cyc = 0; cs_bad = 0; tr_bad = 0;
        start_i = st; sby_enter_i = en; sby_exit_i = ex; addr_i = a; data_i = d;
        while (!got && cnt < 40*H) begin
            @(negedge clk);
            cnt++;
            if (cnt == 1) begin
                start_i = 0; sby_enter_i = 0; sby_exit_i = 0;
                check(busy_o && !pnl_cs_n, {"R2 accept ", tag}, {busy_o, pnl_cs_n}, 2'b10);
            end
            if (cnt <= H && (pnl_sdo || pnl_sclk)) leadbad++;
            if (disturb && cnt == 7) begin
                start_i = 1; addr_i = ~a; data_i = ~d; sby_enter_i = 1; sby_exit_i = 1;
            end
            if (disturb && cnt == 8) begin
                start_i = 0; sby_enter_i = 0; sby_exit_i = 0;
            end
            if (done_o) got = 1;
        end
        check(cnt == 34*H+1, {"R6 frame length ", tag}, cnt, 34*H+1);
        check(!busy_o, {"R6 busy with done ", tag}, busy_o, 0);
        check(cap == expf, {"R3 frame bits ", tag}, cap, expf);
        check(nbits == 16, {"R3 bit count ", tag}, nbits, 16);
        check(hi_cyc == 16*H, {"R4 high time ", tag}, hi_cyc, 16*H);
        check(lo_cyc == 17*H, {"R4 low time ", tag}, lo_cyc, 17*H);
        check(leadbad == 0, {"R2 lead-in quiet ", tag}, leadbad, 0);
        check(tr_cyc == H && tr_bad == 0, {"R5 trailing gap ", tag}, tr_cyc, H);
        check(cs_bad == 0, {"R5 clock outside select ", tag}, cs_bad, 0);
        @(negedge clk);
        check(!done_o, {"R6 done width ", tag}, done_o, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(pnl_cs_n && !pnl_sclk && !pnl_sdo && !busy_o && !done_o, "R1 in reset",
              {pnl_cs_n, pnl_sclk, pnl_sdo, busy_o, done_o}, 5'b10000);
        rst_n = 1;
        repeat (2) @(negedge clk);
        check(pnl_cs_n && !pnl_sclk && !pnl_sdo && !busy_o && !done_o, "R1 after reset",
              {pnl_cs_n, pnl_sclk, pnl_sdo, busy_o, done_o}, 5'b10000);

        foreach (VEC[i]) begin
            logic [1:0] k = VEC[i][16:15];
            logic [6:0] a = VEC[i][14:8];
            logic [7:0] d = VEC[i][7:0];
            if (k == 0) run(1, 0, 0, a, d, {a, 1'b0, d}, "R3 cmd", 0);
            else if (k == 1) run(0, 1, 0, a, d, 16'h8620, "R8 enter", 0);
            else run(0, 0, 1, a, d, 16'h86E0, "R9 exit", 0);
            check(pnl_cs_n && !pnl_sclk && !pnl_sdo && !busy_o, "R1 idle between",
                  {pnl_cs_n, pnl_sclk, pnl_sdo}, 3'b100);
        end

        // R7: strobes during a frame change nothing
        run(1, 0, 0, 7'h51, 8'h3C, {7'h51, 1'b0, 8'h3C}, "R7 disturbed", 1);
        begin
            int extra = 0;
            repeat (5 * H) begin
                @(negedge clk);
                if (busy_o || !pnl_cs_n) extra++;
            end
            check(extra == 0, "R7 no second frame", extra, 0);
        end

        // R10: priority of coinciding strobes
        run(1, 1, 1, 7'h0C, 8'h81, {7'h0C, 1'b0, 8'h81}, "R10 start wins", 0);
        run(0, 1, 1, 7'h0C, 8'h81, 16'h8620, "R10 enter wins", 0);

        // R1: reset in mid-frame returns lines to idle
        @(negedge clk);
        start_i = 1; addr_i = 7'h7F; data_i = 8'hFF;
        @(negedge clk);
        start_i = 0;
        repeat (10) @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        check(pnl_cs_n && !pnl_sclk && !pnl_sdo && !busy_o, "R1 mid-frame reset",
              {pnl_cs_n, pnl_sclk, pnl_sdo, busy_o}, 4'b1000);
        rst_n = 1;
        run(0, 0, 1, 7'h00, 8'h00, 16'h86E0, "R9 after reset", 0);

        summary();
    end
endmodule